// File: doc/BRIEF.md
# Multi-Channel SPI ADC Scan Sequencer

This block is an SPI master that reads a serial successive-approximation converter across a fixed set of input channels in one burst. A single start pulse pulls chip select low and the block then walks through the channels in ascending order. For every channel it runs one four-byte full-duplex exchange. The first byte sent is a generated control byte that selects the channel, and the remaining three bytes are zero. From the bytes received in the same exchange it rebuilds a 16-bit sample and writes it into a per-channel result register.

Chip select stays low for the whole burst. Between exchanges there is a quiet gap of at least one SPI clock period. After the final channel is stored, chip select is released, the busy output drops, and a data-available flag is raised. The flag stays up until a clear pulse or the next accepted start. A start pulse that arrives while a burst is running is ignored.

The SPI clock is derived from the system clock by a parameterised divider. With the default setting it runs at one sixteenth of the system clock.

Top module: `adc_scan_seq`

## Requirements
- R1: The link uses SPI mode 0. `sclk` is low whenever chip select is high. MOSI changes only while `sclk` is low and is stable while `sclk` is high. Each byte has 8 bits and is sent most significant bit first. MISO is captured on the rising edge.
- R2: Within a byte, consecutive rising edges of `sclk` are CLK_DIV system clocks apart (16 by default).
- R3: Each channel exchange is exactly 4 bytes (32 `sclk` pulses). The first transmitted byte is the control byte and the other three transmitted bytes are 0x00.
- R4: The control byte has the following fields: bit 7 = 1 (start bit), bits 6:4 = channel number, bit 3 = 0, bit 2 = 1 (single-ended), bits 1:0 = 2'b11 (power mode).
- R5: With received bytes r0..r3 of one exchange, the stored sample is ((r1 << 9) | (r2 << 1) | (r3 >> 7)) truncated to 16 bits. In bit terms this is {r1[6:0], r2, r3[7]}. The byte r0 is discarded.
- R6: A burst covers channels 0 to NUM_CH-1 (default 7) in ascending order, one exchange each, and then stops with no further `sclk` activity.
- R7: `cs_n` is active low. It falls when a start is accepted, stays low across all exchanges of the burst, and rises only after the last channel is stored.
- R8: `avail` rises in the cycle in which the burst ends. It then stays high until either `clr_avail` or an accepted `start` clears it. A clear leaves the result registers untouched.
- R9: A `start` pulse while `busy` is high is ignored. The running burst neither restarts nor changes its channel order.
- R10: Result register k (bits 16k+15:16k of `results`) is updated when the exchange for channel k completes, while the burst is still running. `busy` is high from the accepted start until `cs_n` rises.
- R11: Between the last falling `sclk` edge of one exchange and the first rising edge of the next, at least CLK_DIV system clocks pass, and `cs_n` stays low throughout.
- R12: A synchronous active-high `rst` returns the block to idle with `cs_n` = 1, `sclk` = 0, `busy` = 0, `avail` = 0 and all results at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a burst when idle |
| clr_avail | input | 1 | Pulse that clears the data-available flag |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data to the converter |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | High while a burst is running |
| avail | output | 1 | Data-available flag |
| results | output | NUM_CH*16 | Packed result registers, channel k at bits 16k+15:16k |

## Verification
The hardest situation to bring about is a start pulse landing in the middle of a running burst. Such a pulse must be shown to leave the channel order and the chip select untouched. The stimulus therefore fires a second start after the second exchange of one burst, and the bench then confirms that exactly seven control bytes were sent, carrying the channel numbers 0 to 6 in order.

Sample assembly is exercised with all-ones and all-zero converter frames. A pattern frame and seeded random frames cover the 1-bit offset across three bytes. Both ways of clearing the flag are tested: a clear pulse, and a start issued while the flag is still set.

// File: rtl/adc_scan_pkg.sv
`timescale 1ns/1ps
package adc_scan_pkg;

   localparam int XFER_BYTES = 4;
   localparam int BYTE_W     = 8;
   localparam int SAMPLE_W   = 16;
   localparam int CTRL_CH_W  = 3;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEND,
      ST_WAIT,
      ST_GAP
   } scan_state_t;

   function automatic logic [BYTE_W-1:0] make_ctrl(input logic [CTRL_CH_W-1:0] chan);
      return {1'b1, chan, 1'b0, 1'b1, 2'b11};
   endfunction

   function automatic logic [SAMPLE_W-1:0] assemble(input logic [BYTE_W-1:0] b1,
                                                    input logic [BYTE_W-1:0] b2,
                                                    input logic [BYTE_W-1:0] b3);
      return SAMPLE_W'({b1, b2, b3} >> 7);
   endfunction

endpackage

// File: rtl/spi_half_tick.sv
`timescale 1ns/1ps
module spi_half_tick #(
   parameter int HALF = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         cnt <= '0;
      end else if (cnt == LAST) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spi_byte_engine.sv
`timescale 1ns/1ps
module spi_byte_engine #(
   parameter int BITS      = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            go,
   input  logic [BITS-1:0] tx,
   input  logic            tick,
   input  logic            miso,
   output logic            sclk,
   output logic            mosi,
   output logic [BITS-1:0] rx,
   output logic            done,
   output logic            active
);
   localparam int BC_W = (BITS > 1) ? $clog2(BITS) : 1;
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(BITS - 1);

   logic [BITS-1:0] shreg;
   logic [BC_W-1:0] bcnt;
   logic [BITS-1:0] shreg_next;
   logic [BITS-1:0] rx_next;
   logic            out_bit;

   generate
      if (MSB_FIRST) begin : g_msb
         assign out_bit    = shreg[BITS-1];
         assign shreg_next = {shreg[BITS-2:0], 1'b0};
         assign rx_next    = {rx[BITS-2:0], miso};
      end else begin : g_lsb
         assign out_bit    = shreg[0];
         assign shreg_next = {1'b0, shreg[BITS-1:1]};
         assign rx_next    = {miso, rx[BITS-1:1]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg  <= '0;
         bcnt   <= '0;
         rx     <= '0;
         sclk   <= 1'b0;
         done   <= 1'b0;
         active <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (go) begin
               shreg  <= tx;
               bcnt   <= '0;
               rx     <= '0;
               sclk   <= 1'b0;
               active <= 1'b1;
            end
         end else if (tick) begin
            if (!sclk) begin
               sclk <= 1'b1;
               rx   <= rx_next;
            end else begin
               sclk <= 1'b0;
               if (bcnt == BC_LAST) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  shreg <= shreg_next;
                  bcnt  <= bcnt + 1'b1;
               end
            end
         end
      end
   end

   assign mosi = active ? out_bit : 1'b0;
endmodule

// File: rtl/adc_scan_ctrl.sv
`timescale 1ns/1ps
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH     = 7,
   parameter int GAP_CYCLES = 16,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic                clr,
   input  logic                eng_done,
   input  logic [BYTE_W-1:0]   eng_rx,
   output logic                eng_go,
   output logic [BYTE_W-1:0]   eng_tx,
   output logic                cs_n,
   output logic                busy,
   output logic                avail,
   output logic                wr_en,
   output logic [CH_W-1:0]     wr_idx,
   output logic [SAMPLE_W-1:0] wr_data
);
   localparam int GAP_W = $clog2(GAP_CYCLES + 1);
   localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP_CYCLES - 1);
   localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);
   localparam logic [1:0]       B_LAST   = 2'(XFER_BYTES - 1);

   scan_state_t       state;
   logic [CH_W-1:0]   chan;
   logic [1:0]        bidx;
   logic [BYTE_W-1:0] rx1;
   logic [BYTE_W-1:0] rx2;
   logic [GAP_W-1:0]  gap;
   logic              last_byte;

   assign last_byte = (state == ST_WAIT) && eng_done && (bidx == B_LAST);
   assign eng_go    = (state == ST_SEND);
   assign eng_tx    = (bidx == 2'd0) ? make_ctrl(CTRL_CH_W'(chan)) : '0;
   assign wr_en     = last_byte;
   assign wr_idx    = chan;
   assign wr_data   = assemble(rx1, rx2, eng_rx);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         chan  <= '0;
         bidx  <= '0;
         rx1   <= '0;
         rx2   <= '0;
         gap   <= '0;
         cs_n  <= 1'b1;
         busy  <= 1'b0;
         avail <= 1'b0;
      end else begin
         if (clr) begin
            avail <= 1'b0;
         end
         case (state)
            ST_IDLE: begin
               if (start) begin
                  avail <= 1'b0;
                  cs_n  <= 1'b0;
                  busy  <= 1'b1;
                  chan  <= '0;
                  bidx  <= '0;
                  state <= ST_SEND;
               end
            end
            ST_SEND: begin
               state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (eng_done) begin
                  if (bidx == 2'd1) begin
                     rx1 <= eng_rx;
                  end
                  if (bidx == 2'd2) begin
                     rx2 <= eng_rx;
                  end
                  if (bidx == B_LAST) begin
                     if (chan == CH_LAST) begin
                        cs_n  <= 1'b1;
                        busy  <= 1'b0;
                        avail <= 1'b1;
                        state <= ST_IDLE;
                     end else begin
                        gap   <= GAP_LOAD;
                        state <= ST_GAP;
                     end
                  end else begin
                     bidx  <= bidx + 1'b1;
                     state <= ST_SEND;
                  end
               end
            end
            ST_GAP: begin
               if (gap == '0) begin
                  chan  <= chan + 1'b1;
                  bidx  <= '0;
                  state <= ST_SEND;
               end else begin
                  gap <= gap - 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank #(
   parameter int NUM_CH = 7,
   parameter int W      = 16,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic [CH_W-1:0]     wr_idx,
   input  logic [W-1:0]        wr_data,
   output logic [NUM_CH*W-1:0] flat
);
   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (rst) begin
               slot <= '0;
            end else if (wr_en && (wr_idx == CH_W'(k))) begin
               slot <= wr_data;
            end
         end
         assign flat[k*W +: W] = slot;
      end
   endgenerate
endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int NUM_CH      = 7,
   parameter int CLK_DIV     = 16,
   parameter int GAP_PERIODS = 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       start,
   input  logic                       clr_avail,
   input  logic                       miso,
   output logic                       sclk,
   output logic                       mosi,
   output logic                       cs_n,
   output logic                       busy,
   output logic                       avail,
   output logic [NUM_CH*SAMPLE_W-1:0] results
);
   localparam int HALF       = CLK_DIV / 2;
   localparam int GAP_CYCLES = GAP_PERIODS * CLK_DIV;
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << CTRL_CH_W)) begin : g_bad_ch
         $error("NUM_CH must fit the control byte channel field");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (GAP_PERIODS < 1) begin : g_bad_gap
         $error("GAP_PERIODS must be at least 1");
      end
   endgenerate

   logic                tick;
   logic                eng_active;
   logic                eng_go;
   logic                eng_done;
   logic [BYTE_W-1:0]   eng_tx;
   logic [BYTE_W-1:0]   eng_rx;
   logic                wr_en;
   logic [CH_W-1:0]     wr_idx;
   logic [SAMPLE_W-1:0] wr_data;

   spi_half_tick #(.HALF(HALF)) u_div (
      .clk  (clk),
      .rst  (rst),
      .run  (eng_active),
      .tick (tick)
   );

   spi_byte_engine #(.BITS(BYTE_W), .MSB_FIRST(1'b1)) u_eng (
      .clk    (clk),
      .rst    (rst),
      .go     (eng_go),
      .tx     (eng_tx),
      .tick   (tick),
      .miso   (miso),
      .sclk   (sclk),
      .mosi   (mosi),
      .rx     (eng_rx),
      .done   (eng_done),
      .active (eng_active)
   );

   adc_scan_ctrl #(.NUM_CH(NUM_CH), .GAP_CYCLES(GAP_CYCLES)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .clr      (clr_avail),
      .eng_done (eng_done),
      .eng_rx   (eng_rx),
      .eng_go   (eng_go),
      .eng_tx   (eng_tx),
      .cs_n     (cs_n),
      .busy     (busy),
      .avail    (avail),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data)
   );

   adc_result_bank #(.NUM_CH(NUM_CH), .W(SAMPLE_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .flat    (results)
   );
endmodule

// File: rtl/adc_scan_chk.sv
`timescale 1ns/1ps
module adc_scan_chk (
   input logic clk,
   input logic rst,
   input logic start,
   input logic sclk,
   input logic mosi,
   input logic cs_n,
   input logic busy,
   input logic avail
);
   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> !sclk); // R1

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk)) |-> $stable(mosi)); // R1

   AST_CS_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |-> !cs_n); // R7

   AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !busy |-> cs_n); // R10

   AST_AVAIL_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      avail |-> !busy); // R8

   AST_AVAIL_AT_END: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> avail); // R8

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(start)); // R9

   AST_SCLK_IN_BURST: assert property (@(posedge clk) disable iff (rst)
      sclk |-> busy); // R7
endmodule

bind adc_scan_seq adc_scan_chk u_chk (
   .clk   (clk),
   .rst   (rst),
   .start (start),
   .sclk  (sclk),
   .mosi  (mosi),
   .cs_n  (cs_n),
   .busy  (busy),
   .avail (avail)
);

// File: tb/tb_adc_scan_seq.sv
`timescale 1ns/1ps
module tb_adc_scan_seq;
   localparam int NUM_CH  = 7;
   localparam int CLK_DIV = 16;
   localparam real PER    = 10.0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic clr_avail = 1'b0;
   logic miso = 1'b0;
   logic sclk, mosi, cs_n, busy, avail;
   logic [NUM_CH*16-1:0] results;

   int checks = 0;
   int errs = 0;
   int cycles = 0;
   int xfer_cnt = 0;
   logic [31:0] frames [NUM_CH];
   logic [31:0] caps [NUM_CH];

   adc_scan_seq #(.NUM_CH(NUM_CH), .CLK_DIV(CLK_DIV)) dut (
      .clk(clk), .rst(rst), .start(start), .clr_avail(clr_avail), .miso(miso),
      .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .avail(avail),
      .results(results)
   );

   always #5 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_ctrl(input int ch);
      logic [2:0] c = 3'(ch);
      return {1'b1, c, 1'b0, 1'b1, 2'b11};
   endfunction

   function automatic logic [15:0] exp_sample(input logic [31:0] f);
      return {f[22:16], f[15:8], f[7]};
   endfunction

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
         end
      end
   end

   // converter model: drives MISO, captures MOSI, measures clock timing
   initial begin
      realtime t_rise, t_fall, tnow;
      logic [31:0] cap;
      t_rise = 0;
      t_fall = 0;
      forever begin
         @(negedge cs_n);
         xfer_cnt = 0;
         for (int c = 0; c < NUM_CH; c++) begin
            cap = '0;
            for (int b = 0; b < 32; b++) begin
               miso = frames[c][31-b];
               @(posedge sclk);
               tnow = $realtime;
               if (b == 0 && c > 0) begin
                  check("R11 gap>=CLK_DIV", 32'(tnow - t_fall >= CLK_DIV * PER), 32'd1);
                  check("R11 cs_n low in gap", 32'(cs_n), 32'd0);
               end
               if ((b % 8) != 0) begin
                  check("R2 sclk period", 32'(int'((tnow - t_rise) / PER)), 32'(CLK_DIV));
               end
               t_rise = tnow;
               cap = {cap[30:0], mosi};
               @(negedge sclk);
               t_fall = $realtime;
            end
            caps[c] = cap;
            xfer_cnt++;
         end
      end
   end

   task automatic tick_n(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse(input bit which);
      @(posedge clk);
      #1;
      if (which) start = 1'b1; else clr_avail = 1'b1;
      @(posedge clk);
      #1;
      start = 1'b0;
      clr_avail = 1'b0;
   endtask

   task automatic run_scan(input int s, input bit mid_start);
      for (int c = 0; c < NUM_CH; c++) begin
         case (s)
            0: frames[c] = 32'hFFFF_FFFF;
            1: frames[c] = 32'h0000_0000;
            2: frames[c] = 32'hA5C3_5A3C ^ {c[7:0], c[7:0], c[7:0], c[7:0]};
            default: frames[c] = $urandom;
         endcase
      end
      pulse(1'b1);
      check("R7 cs_n low after start", 32'(cs_n), 32'd0);
      check("R10 busy after start", 32'(busy), 32'd1);
      check("R8 avail cleared by start", 32'(avail), 32'd0);
      wait (xfer_cnt == 1);
      tick_n(4);
      check("R10 result0 during burst", 32'(results[15:0]), 32'(exp_sample(frames[0])));
      check("R10 busy mid burst", 32'(busy), 32'd1);
      if (mid_start) begin
         wait (xfer_cnt == 2);
         tick_n(3);
         pulse(1'b1);
         check("R9 cs_n kept on start", 32'(cs_n), 32'd0);
      end
      while (!avail) @(posedge clk);
      #1;
      check("R8 avail at end", 32'(avail), 32'd1);
      check("R7 cs_n released", 32'(cs_n), 32'd1);
      check("R10 busy low at end", 32'(busy), 32'd0);
      check("R6 exchange count", 32'(xfer_cnt), 32'(NUM_CH));
      for (int c = 0; c < NUM_CH; c++) begin
         check("R5 sample", 32'(results[c*16 +: 16]), 32'(exp_sample(frames[c])));
         check("R4 control byte", 32'(caps[c][31:24]), 32'(exp_ctrl(c)));
         check("R3 zero tail bytes", 32'(caps[c][23:0]), 32'd0);
      end
      tick_n(200);
      check("R6 no further sclk", 32'(xfer_cnt), 32'(NUM_CH));
      check("R1 sclk idle low", 32'(sclk), 32'd0);
   endtask

   initial begin
      logic [NUM_CH*16-1:0] snap;
      void'($urandom(32'd77123));
      tick_n(3);
      check("R12 cs_n reset", 32'(cs_n), 32'd1);
      check("R12 sclk reset", 32'(sclk), 32'd0);
      check("R12 busy reset", 32'(busy), 32'd0);
      check("R12 avail reset", 32'(avail), 32'd0);
      check("R12 results reset", 32'(results[31:0]), 32'd0);
      rst = 1'b0;
      tick_n(2);

      run_scan(0, 1'b0);
      snap = results;
      pulse(1'b0);
      check("R8 clr clears avail", 32'(avail), 32'd0);
      check("R8 clr keeps results", 32'(snap == results), 32'd1);

      run_scan(1, 1'b0);
      run_scan(2, 1'b1);
      run_scan(3, 1'b1);
      run_scan(4, 1'b0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule